// File: doc/BRIEF.md
# Asynchronous IR Bit-Rate Generator with Receive Idle Timeout

This block derives the timing for the slow asynchronous infrared link from a fixed 48 MHz clock. A fixed divide-by-26 prescaler produces a one-cycle enable every 26 clocks. A 6-bit reload counter, programmed with a value N, divides that enable further to give the 16x oversampling tick. The resulting bit rate is 48 MHz / 26 / 16 / (N + 1). Every sixteenth tick is also issued as a bit strobe. N = 11 gives 9600 bit/s and is the value after reset.

The same bit strobe clocks a receive idle detector. It counts bit periods in which the receiver reports no activity. It raises a single-cycle timeout pulse when the idle gap reaches 4 or 8 character times, as chosen by a 2-bit select. The detector is a three-state machine:

- TO_OFF: the detector is disabled.
- TO_WATCH: the detector is counting idle bit periods.
- TO_SPENT: the timeout has fired and the detector waits for activity.

The transitions are:

- enable: TO_OFF to TO_WATCH.
- expire: TO_WATCH to TO_SPENT.
- rearm: TO_SPENT to TO_WATCH, taken on receive activity.
- disable: TO_WATCH or TO_SPENT to TO_OFF, taken when the effective select becomes 0.

The timeout is honoured only while the asynchronous mode input is high. Otherwise the effective select is 0.

Top module: `irb_baud_gen`

## Requirements
- R1: After reset all three outputs are low, N is 11 and the timeout select is 2. With N = 11 the spacing between successive ticks is 312 cycles.
- R2: Successive 16x ticks are 26 × (N + 1) clock cycles apart.
- R3: `tick16_o` is a single-cycle pulse and is only asserted on a prescaler enable cycle.
- R4: `bit_stb_o` is asserted together with every 16th tick, so that 16 ticks separate two bit strobes.
- R5: A write of N (`rate_val_i[5:0]`) leaves the tick interval in progress unchanged. The new value governs the intervals from the next reload onward, so no shortened interval is produced.
- R6: The timeout select takes these values:
    - 0 disables the detector.
    - 1 fires after 4 × CHAR_BITS idle bit strobes.
    - 2 fires after 8 × CHAR_BITS idle bit strobes.

  CHAR_BITS defaults to 10.
- R7: `rx_timeout_o` is a one-cycle pulse in the cycle after the bit strobe that completes the idle interval.
- R8: A write of select value 3 is ignored, and the previous select stays in force.
- R9: While `async_mode_i` is low the effective select is 0: no timeout fires and the idle count is discarded.
- R10: `rx_activity_i` restarts the idle count. When activity and the completing strobe fall in the same cycle, activity wins, no timeout fires, and a full new interval starts.
- R11: The timeout fires once per idle gap. After it fires, another one requires receive activity first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz clock |
| rst_n | input | 1 | Active-low synchronous reset |
| async_mode_i | input | 1 | High while the link is in slow asynchronous mode |
| rate_wr_i | input | 1 | Write strobe for the reload count |
| rate_val_i | input | 6 | Reload count N |
| tmo_wr_i | input | 1 | Write strobe for the timeout select |
| tmo_sel_i | input | 2 | Timeout select (0 off, 1 short, 2 long, 3 ignored) |
| rx_activity_i | input | 1 | Receiver saw line activity this cycle |
| tick16_o | output | 1 | 16x oversampling tick |
| bit_stb_o | output | 1 | Bit-period strobe |
| rx_timeout_o | output | 1 | Receive idle timeout pulse |

## Verification
The collision of interest is between receive activity and the bit strobe that would complete an idle interval. The bench counts strobes after an activity pulse up to one short of the limit. It then waits for the cycle in which the final strobe is visible and raises activity in that same cycle. The bench then expects no timeout in the following cycle, and a full fresh interval of strobes before the next pulse. A behavioural reference model compared on every clock also judges each such coincidence.

// File: rtl/irb_pkg.sv
package irb_pkg;

    typedef enum logic [1:0] {
        TO_OFF   = 2'd0,
        TO_WATCH = 2'd1,
        TO_SPENT = 2'd2
    } idle_state_e;

    typedef enum logic [1:0] {
        TSEL_NONE  = 2'd0,
        TSEL_SHORT = 2'd1,
        TSEL_LONG  = 2'd2,
        TSEL_BAD   = 2'd3
    } tmo_sel_e;

endpackage

// File: rtl/irb_prescale.sv
module irb_prescale #(
    parameter int DIV = 26
) (
    input  logic clk,
    input  logic rst_n,
    output logic en_o
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] ph_q;

    always_ff @(posedge clk) begin
        if (!rst_n)            ph_q <= '0;
        else if (ph_q == LAST) ph_q <= '0;
        else                   ph_q <= ph_q + 1'b1;
    end

    assign en_o = (ph_q == LAST);

    // R2: enables are never back to back
    p_en_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        en_o |=> !en_o);
endmodule

// File: rtl/irb_rate_cnt.sv
module irb_rate_cnt #(
    parameter int CNT_W = 6,
    parameter int OVS   = 16,
    parameter int DEF_N = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic             tick_o,
    output logic             bit_o
);
    localparam int OW = $clog2(OVS);
    localparam logic [OW-1:0] OVS_LAST = OW'(OVS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] n_q;
    logic [OW-1:0]    ovs_q;

    // Reload value: picked up by the counter only at its next reload
    always_ff @(posedge clk) begin
        if (!rst_n)    n_q <= CNT_W'(DEF_N);
        else if (wr_i) n_q <= wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= CNT_W'(DEF_N);
        else if (step_i)
            cnt_q <= (cnt_q == '0) ? n_q : cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ovs_q <= '0;
        else if (tick_o)
            ovs_q <= (ovs_q == OVS_LAST) ? '0 : ovs_q + 1'b1;
    end

    assign tick_o = step_i && (cnt_q == '0);
    assign bit_o  = tick_o && (ovs_q == OVS_LAST);

    // R5: counter only moves on a prescaler enable, whatever is written
    p_hold_between_steps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(cnt_q));
    // R4: a tick that is not a bit strobe leaves the phase off zero
    p_phase_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && !bit_o) |=> (ovs_q != '0));
endmodule

// File: rtl/irb_idle_fsm.sv
module irb_idle_fsm
    import irb_pkg::*;
#(
    parameter int CHAR_BITS = 10,
    parameter int DEF_SEL   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_i,
    input  logic       wr_i,
    input  logic [1:0] wsel_i,
    input  logic       act_i,
    input  logic       bit_i,
    output logic       tmo_o
);
    localparam int LIM_SHORT = 4 * CHAR_BITS;
    localparam int LIM_LONG  = 8 * CHAR_BITS;
    localparam int IW        = $clog2(LIM_LONG + 1);

    tmo_sel_e    sel_q, eff_sel;
    idle_state_e state_q, state_d;
    logic [IW-1:0] idle_q, idle_d, limit;
    logic        fire_d;

    // Select register: the reserved code is dropped
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= tmo_sel_e'(DEF_SEL);
        else if (wr_i && (wsel_i != 2'd3))
            sel_q <= tmo_sel_e'(wsel_i);
    end

    assign eff_sel = mode_i ? sel_q : TSEL_NONE;

    always_comb begin
        case (eff_sel)
            TSEL_SHORT: limit = IW'(LIM_SHORT);
            TSEL_LONG:  limit = IW'(LIM_LONG);
            default:    limit = '0;
        endcase
    end

    // Next state and pulse
    always_comb begin
        state_d = state_q;
        idle_d  = idle_q;
        fire_d  = 1'b0;
        unique case (state_q)
            TO_OFF: begin
                if (eff_sel != TSEL_NONE) begin
                    state_d = TO_WATCH;
                    idle_d  = '0;
                end
            end
            TO_WATCH: begin
                if (eff_sel == TSEL_NONE) begin
                    state_d = TO_OFF;
                end else if (act_i) begin
                    idle_d = '0;
                end else if (bit_i) begin
                    if (IW'(idle_q + 1'b1) >= limit) begin
                        fire_d  = 1'b1;
                        state_d = TO_SPENT;
                    end else begin
                        idle_d = idle_q + 1'b1;
                    end
                end
            end
            TO_SPENT: begin
                if (eff_sel == TSEL_NONE) begin
                    state_d = TO_OFF;
                end else if (act_i) begin
                    state_d = TO_WATCH;
                    idle_d  = '0;
                end
            end
            default: state_d = TO_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TO_OFF;
            idle_q  <= '0;
        end else begin
            state_q <= state_d;
            idle_q  <= idle_d;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) tmo_o <= 1'b0;
        else        tmo_o <= fire_d;
    end

    p_sel_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q != TSEL_BAD);
    p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_i |=> !tmo_o);
    p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_o |=> !tmo_o);
    p_fire_spent_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_o |-> (state_q == TO_SPENT));
endmodule

// File: rtl/irb_baud_gen.sv
module irb_baud_gen #(
    parameter int PRE_DIV   = 26,
    parameter int CNT_W     = 6,
    parameter int OVS       = 16,
    parameter int DEF_N     = 11,
    parameter int CHAR_BITS = 10,
    parameter int DEF_SEL   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             async_mode_i,
    input  logic             rate_wr_i,
    input  logic [CNT_W-1:0] rate_val_i,
    input  logic             tmo_wr_i,
    input  logic [1:0]       tmo_sel_i,
    input  logic             rx_activity_i,
    output logic             tick16_o,
    output logic             bit_stb_o,
    output logic             rx_timeout_o
);
    logic pre_en;

    irb_prescale #(.DIV(PRE_DIV)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .en_o (pre_en)
    );

    irb_rate_cnt #(.CNT_W(CNT_W), .OVS(OVS), .DEF_N(DEF_N)) u_rate (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (pre_en),
        .wr_i   (rate_wr_i),
        .wdata_i(rate_val_i),
        .tick_o (tick16_o),
        .bit_o  (bit_stb_o)
    );

    irb_idle_fsm #(.CHAR_BITS(CHAR_BITS), .DEF_SEL(DEF_SEL)) u_idle (
        .clk   (clk),
        .rst_n (rst_n),
        .mode_i(async_mode_i),
        .wr_i  (tmo_wr_i),
        .wsel_i(tmo_sel_i),
        .act_i (rx_activity_i),
        .bit_i (bit_stb_o),
        .tmo_o (rx_timeout_o)
    );

    p_tick_on_prescale_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick16_o |-> pre_en);
    p_tmo_after_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_timeout_o |-> ($past(bit_stb_o) && !$past(rx_activity_i)));
endmodule

// File: tb/sim_irb_baud_gen.sv
module sim_irb_baud_gen;
    localparam int CB  = 5;
    localparam int LS  = 4 * CB;
    localparam int LL  = 8 * CB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic async_mode = 1'b0;
    logic rate_wr = 1'b0;
    logic [5:0] rate_val = '0;
    logic tmo_wr = 1'b0;
    logic [1:0] tmo_sel = '0;
    logic act = 1'b0;
    logic tick16, bit_stb, rx_tmo;

    int total = 0;
    int fails = 0;

    irb_baud_gen #(.CHAR_BITS(CB)) u0 (
        .clk(clk), .rst_n(rst_n), .async_mode_i(async_mode),
        .rate_wr_i(rate_wr), .rate_val_i(rate_val),
        .tmo_wr_i(tmo_wr), .tmo_sel_i(tmo_sel),
        .rx_activity_i(act), .tick16_o(tick16), .bit_stb_o(bit_stb),
        .rx_timeout_o(rx_tmo)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int got, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, got, exp, $time);
        end
    endtask

    // Behavioural reference model
    int m_pre, m_cnt, m_n, m_ovs, m_sel, m_st, m_idle, m_tmo;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 0; m_cnt = 11; m_n = 11; m_ovs = 0;
            m_sel = 2; m_st = 0; m_idle = 0; m_tmo = 0;
        end else begin
            bit pe, tk, bs;
            int eff, lim, nt;
            pe = (m_pre == 25);
            tk = pe && (m_cnt == 0);
            bs = tk && (m_ovs == 15);
            eff = async_mode ? m_sel : 0;
            lim = (eff == 1) ? LS : (eff == 2) ? LL : 0;
            nt = 0;
            if (m_st == 0) begin
                if (eff != 0) begin m_st = 1; m_idle = 0; end
            end else if (m_st == 1) begin
                if (eff == 0) m_st = 0;
                else if (act) m_idle = 0;
                else if (bs) begin
                    if (m_idle + 1 >= lim) begin nt = 1; m_st = 2; end
                    else m_idle++;
                end
            end else begin
                if (eff == 0) m_st = 0;
                else if (act) begin m_st = 1; m_idle = 0; end
            end
            m_pre = pe ? 0 : m_pre + 1;
            if (pe) m_cnt = (m_cnt == 0) ? m_n : m_cnt - 1;
            if (tk) m_ovs = (m_ovs + 1) % 16;
            if (rate_wr) m_n = rate_val;
            if (tmo_wr && tmo_sel != 2'd3) m_sel = tmo_sel;
            m_tmo = nt;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            bit et, eb;
            et = (m_pre == 25) && (m_cnt == 0);
            eb = et && (m_ovs == 15);
            chk(tick16 == et, "R3 model tick16", tick16, et);
            chk(bit_stb == eb, "R4 model bit_stb", bit_stb, eb);
            chk(rx_tmo == m_tmo[0], "R7 model rx_timeout", rx_tmo, m_tmo);
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    task automatic wait_tick(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!tick16);
    endtask

    task automatic wr_rate(input int v);
        rate_val = 6'(v); rate_wr = 1'b1;
        @(negedge clk); rate_wr = 1'b0;
    endtask

    task automatic wr_sel(input int v);
        tmo_sel = 2'(v); tmo_wr = 1'b1;
        @(negedge clk); tmo_wr = 1'b0;
    endtask

    task automatic pulse_act();
        act = 1'b1; @(negedge clk); act = 1'b0;
    endtask

    task automatic count_tmo(input int max_s, output int s, output bit got);
        s = 0; got = 0;
        while (!got && s <= max_s) begin
            if (rx_tmo) got = 1;
            else begin
                if (bit_stb) s++;
                @(negedge clk);
            end
        end
    endtask

    initial begin
        int n, d, s;
        bit got;
        repeat (4) @(negedge clk);
        chk(!tick16 && !bit_stb && !rx_tmo, "R1 reset outputs", {tick16, bit_stb, rx_tmo}, 0);
        rst_n = 1'b1;

        wait_tick(n);
        wait_tick(n);
        chk(n == 312, "R1 default N=11 interval", n, 312);

        wr_rate(3);
        wait_tick(n);
        wait_tick(n);
        wait_tick(n);
        chk(n == 104, "R2 N=3 interval", n, 104);

        repeat (9) @(negedge clk);
        wr_rate(0);
        wait_tick(d);
        chk(10 + d == 104, "R5 interval in progress kept", 10 + d, 104);
        wait_tick(n);
        chk(n == 26, "R5 new N after reload", n, 26);
        chk(n == 26, "R2 N=0 interval", n, 26);
        @(negedge clk);
        chk(tick16 == 1'b0, "R3 tick single cycle", tick16, 0);

        do @(negedge clk); while (!bit_stb);
        n = 0;
        do begin @(negedge clk); if (tick16) n++; end while (!bit_stb);
        chk(n == 16, "R4 ticks per bit strobe", n, 16);

        async_mode = 1'b1;
        pulse_act();
        count_tmo(LL + 5, s, got);
        chk(got && s == LL, "R6 long select strobes", s, LL);
        chk(got, "R7 timeout pulse seen", got, 1);
        @(negedge clk);
        count_tmo(LL + 10, s, got);
        chk(!got, "R11 no second timeout in gap", got, 0);

        wr_sel(1);
        pulse_act();
        count_tmo(LL, s, got);
        chk(got && s == LS, "R6 short select strobes", s, LS);

        wr_sel(3);
        pulse_act();
        count_tmo(LL, s, got);
        chk(got && s == LS, "R8 reserved select ignored", s, LS);

        pulse_act();
        s = 0;
        forever begin
            if (bit_stb) begin
                if (s == LS - 1) break;
                s++;
            end
            @(negedge clk);
        end
        pulse_act();
        chk(rx_tmo == 1'b0, "R10 activity wins same-cycle strobe", rx_tmo, 0);
        count_tmo(LL, s, got);
        chk(got && s == LS, "R10 full interval after collision", s, LS);

        async_mode = 1'b0;
        pulse_act();
        count_tmo(LS + 10, s, got);
        chk(!got, "R9 no timeout outside async mode", got, 0);

        async_mode = 1'b1;
        wr_sel(0);
        pulse_act();
        count_tmo(LS + 5, s, got);
        chk(!got, "R6 select 0 disables", got, 0);

        finish_run();
    end
endmodule